// File: doc/BRIEF.md
# Stretchable Quadrature Bus Clock Generator

This block derives the two phase clocks of an 8-bit processor bus, E and Q, from one system clock. Both clocks run at a quarter of the system rate. Q leads E by one system-clock phase, which is ninety degrees of the bus cycle. The four phases of a bus cycle step through a divide-by-four chain built from two toggle stages. A one-clock strobe marks the end of every bus cycle, that is, every falling edge of E.

A slow device can hold the bus cycle open by pulling an active-low ready line low. Two flops synchronize that line. It is looked at in only one phase: E high with Q already low. While ready is low in that phase, the phase sequence freezes with E high.

Dynamic state inside the processor must not be starved. A stretch timer therefore counts held clocks against a parameter that holds the time budget in system clocks. It raises an overrun flag once that budget is used up.

Top module: `quad_clock_gen`

## Requirements
- R1: While the synchronous active-high reset is sampled high, the next clock edge drives E, Q, the cycle-end strobe and the overrun flag low and returns the phase to zero.
- R2: Without stretching, E and Q each repeat with a period of exactly 4 system clocks and are high for 2 of them.
- R3: Reckoned in rising edges after reset release, the pair (E,Q) steps 00, 01, 11, 10 and repeats. Q therefore leads E by one system clock, and only one of the two changes on any edge.
- R4: The cycle-end strobe is high for exactly one system clock, in the clock following each falling edge of E, and is low at all other times.
- R5: The ready input passes through two synchronizer flops. When the synchronized value is low in the phase (E=1,Q=0), that phase is held with E high and Q low for as long as the synchronized value stays low.
- R6: A low on ready that reaches the synchronizer output only during phases 00, 01 or 11 has no effect: the cycle still lasts 4 clocks.
- R7: After ready is driven high again, E falls on the third rising edge. The sequence then resumes at 00 and passes through 01, 11 and 10, with no phase skipped or repeated.
- R8: The overrun flag is low during the first MAX_STRETCH-1 held clocks of a stretch. It rises once MAX_STRETCH held clocks have passed and stays high until the edge on which E falls. The flag is only ever high while (E,Q)=10.
- R9: A stretch shorter than MAX_STRETCH held clocks never raises the overrun flag.
- R10: A reset applied in the middle of a stretch ends it at once and gives the R1 state. Normal cycling resumes after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| bus_ready_i | input | 1 | Active-low ready; low stretches the bus cycle |
| e_o | output | 1 | E phase clock |
| q_o | output | 1 | Q phase clock, leading E by a quarter cycle |
| cycle_end_o | output | 1 | One-clock strobe after each falling edge of E |
| overrun_o | output | 1 | Stretch has used up its clock budget |

## Verification
The bench times the release of a stretch to the exact edge. A synchronizer with one flop too few or too many would move the falling edge of E off the third edge. A resume that skipped or repeated a phase would break the 00, 01, 11, 10 order the bench records after the stretch.

A short low pulse on ready that lands only in the early phases must leave the cycle at 4 clocks. A design that sampled ready in every phase would freeze the wrong phase.

The overrun flag is checked one clock before and one clock after the budget runs out. An off-by-one counter would fail one of those two samples, and a flag that stayed set after the stretch would show up on the resuming cycle.

// File: rtl/quad_clk_pkg.sv
`timescale 1ns/1ps
package quad_clk_pkg;
  localparam int PHASE_BITS = 2;
  typedef logic [PHASE_BITS-1:0] phase_t;
  localparam phase_t PH_SAMPLE = 2'b11;

  function automatic logic phase_e(input phase_t p);
    return p[1];
  endfunction

  function automatic logic phase_q(input phase_t p);
    return p[1] ^ p[0];
  endfunction
endpackage

// File: rtl/qc_ready_sync.sv
`timescale 1ns/1ps
module qc_ready_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) chain_q <= '1;
    else       chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/qc_phase_div.sv
`timescale 1ns/1ps
module qc_phase_div
  import quad_clk_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_i,
  input  logic   advance_i,
  output phase_t phase_o,
  output logic   e_o,
  output logic   q_o,
  output logic   cycle_end_o
);
  localparam int NSTAGE = PHASE_BITS;

  phase_t stage_q;
  phase_t stage_d;
  logic [NSTAGE:0] carry;
  logic e_q, q_q, end_q;

  assign carry[0] = advance_i;
  for (genvar i = 0; i < NSTAGE; i++) begin : g_toggle
    assign carry[i+1] = carry[i] & stage_q[i];
  end

  assign stage_d = stage_q ^ carry[NSTAGE-1:0];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      stage_q <= '0;
      e_q     <= 1'b0;
      q_q     <= 1'b0;
      end_q   <= 1'b0;
    end else begin
      stage_q <= stage_d;
      e_q     <= phase_e(stage_d);
      q_q     <= phase_q(stage_d);
      end_q   <= carry[NSTAGE];
    end
  end

  assign phase_o     = stage_q;
  assign e_o         = e_q;
  assign q_o         = q_q;
  assign cycle_end_o = end_q;

  assert_single_change_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones({e_q, q_q} ^ $past({e_q, q_q})) <= 1);
  assert_strobe_on_fall_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    end_q |-> $fell(e_q));
  assert_free_phases_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (stage_q != PH_SAMPLE) |=> (stage_q != $past(stage_q)));
endmodule

// File: rtl/qc_stretch_timer.sv
`timescale 1ns/1ps
module qc_stretch_timer #(
  parameter int MAX_STRETCH = 100
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic hold_i,
  output logic overrun_o
);
  localparam int CW = $clog2(MAX_STRETCH + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_STRETCH);

  logic [CW-1:0] held_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !hold_i)    held_q <= '0;
    else if (held_q != LIMIT) held_q <= held_q + 1'b1;
  end

  assign overrun_o = (held_q >= LIMIT);

  assert_count_bound_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    held_q <= LIMIT);
  assert_flag_needs_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    overrun_o |-> $past(hold_i));
endmodule

// File: rtl/quad_clock_gen.sv
`timescale 1ns/1ps
module quad_clock_gen
  import quad_clk_pkg::*;
#(
  parameter int MAX_STRETCH = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic bus_ready_i,
  output logic e_o,
  output logic q_o,
  output logic cycle_end_o,
  output logic overrun_o
);
  logic   ready_sync;
  logic   hold;
  logic   advance;
  phase_t phase;

  qc_ready_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .async_i (bus_ready_i),
    .sync_o  (ready_sync)
  );

  assign hold    = (phase == PH_SAMPLE) && !ready_sync;
  assign advance = !hold;

  qc_phase_div u_div (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .advance_i   (advance),
    .phase_o     (phase),
    .e_o         (e_o),
    .q_o         (q_o),
    .cycle_end_o (cycle_end_o)
  );

  qc_stretch_timer #(.MAX_STRETCH(MAX_STRETCH)) u_timer (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .hold_i    (hold),
    .overrun_o (overrun_o)
  );

  assert_reset_state_R1: assert property (@(posedge clk_i)
    rst_i |=> (!e_o && !q_o && !cycle_end_o && !overrun_o));
  assert_hold_keeps_e_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    hold |=> (e_o && !q_o));
  assert_resume_step_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (phase == PH_SAMPLE && ready_sync) |=> (!e_o && cycle_end_o));
  assert_overrun_phase_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    overrun_o |-> (e_o && !q_o));
endmodule

// File: tb/quad_clock_gen_bench.sv
`timescale 1ns/1ps
module quad_clock_gen_bench;
  localparam int MAXS = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rdy = 1'b1;
  logic e, q, cend, ovr;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  quad_clock_gen #(.MAX_STRETCH(MAXS)) u_quad_clock_gen (
    .clk_i(clk), .rst_i(rst), .bus_ready_i(rdy),
    .e_o(e), .q_o(q), .cycle_end_o(cend), .overrun_o(ovr)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic wait_cycle_end();
    for (int i = 0; i < 500; i++) begin
      step();
      if (cend) return;
    end
    check("R4", "cycle end seen", 0, 1);
  endtask

  task automatic wait_e_hold_phase();
    for (int i = 0; i < 500; i++) begin
      step();
      if (e && !q) return;
    end
    check("R5", "reached phase 10", 0, 1);
  endtask

  task automatic check_four_phases(input string req);
    check(req, "phase0 E", e, 0); check(req, "phase0 Q", q, 0); check(req, "phase0 strobe", cend, 1);
    step(); check(req, "phase1 EQ", {e, q}, 2'b01); check(req, "phase1 strobe", cend, 0);
    step(); check(req, "phase2 EQ", {e, q}, 2'b11);
    step(); check(req, "phase3 EQ", {e, q}, 2'b10);
  endtask

  task automatic t_reset();
    rst = 1'b1; rdy = 1'b1;
    repeat (3) step();
    check("R1", "E", e, 0); check("R1", "Q", q, 0);
    check("R1", "strobe", cend, 0); check("R1", "overrun", ovr, 0);
  endtask

  task automatic t_free_run();
    int highs_e = 0;
    rst = 1'b0;
    for (int k = 1; k <= 16; k++) begin
      int ph;
      step();
      ph = k % 4;
      check("R3", "E order", e, (ph >= 2) ? 1 : 0);
      check("R3", "Q order", q, (ph == 1 || ph == 2) ? 1 : 0);
      check("R4", "strobe", cend, (ph == 0) ? 1 : 0);
      if (e) highs_e++;
    end
    check("R2", "E high clocks in 16", highs_e, 8);
  endtask

  task automatic t_stretch(input int held, input string req);
    wait_cycle_end();
    rdy = 1'b0;
    wait_e_hold_phase();
    for (int n = 1; n <= held; n++) begin
      step();
      if (e != 1 || q != 0) check("R5", "held phase EQ", {e, q}, 2'b10);
      if (n == MAXS - 1) check("R8", "overrun before budget", ovr, 0);
      if (n == MAXS)     check("R8", "overrun at budget", ovr, 1);
      if (held < MAXS && ovr) check("R9", "short stretch overrun", ovr, 0);
    end
    check("R5", "E high at end of hold", e, 1);
    rdy = 1'b1;
    step(); check("R7", "edge1 E", e, 1);
    step(); check("R7", "edge2 E", e, 1);
    if (held >= MAXS) check("R8", "overrun held to release", ovr, 1);
    step(); check("R7", "edge3 E falls", e, 0);
    check("R8", "overrun cleared", ovr, 0);
    check_four_phases(req);
  endtask

  task automatic t_ignore();
    wait_cycle_end();
    rdy = 1'b0;
    step(); rdy = 1'b1;
    step(); check("R6", "phase 11", {e, q}, 2'b11);
    step(); check("R6", "phase 10", {e, q}, 2'b10);
    step(); check("R6", "E fell after 4", e, 0);
    check("R6", "strobe", cend, 1); check("R6", "overrun", ovr, 0);
  endtask

  task automatic t_reset_mid();
    wait_cycle_end();
    rdy = 1'b0;
    wait_e_hold_phase();
    repeat (5) step();
    rst = 1'b1;
    step();
    check("R10", "E", e, 0); check("R10", "Q", q, 0);
    check("R10", "strobe", cend, 0); check("R10", "overrun", ovr, 0);
    rdy = 1'b1;
    step(); rst = 1'b0;
    step(); check("R10", "resume EQ", {e, q}, 2'b01);
    step(); check("R10", "resume EQ", {e, q}, 2'b11);
    step(); check("R10", "resume EQ", {e, q}, 2'b10);
    step(); check("R10", "resume E fall", e, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_free_run();
    t_stretch(10, "R7");
    t_stretch(MAXS + 5, "R8");
    t_ignore();
    t_reset_mid();
    repeat (4) step();
    finish_run();
  end

  initial begin
    #2000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end
endmodule